// File: doc/BRIEF.md
# Exception Entry Sequencer

This block takes a processor core into an exception handler. Three request lines feed it: an external interrupt, a software-interrupt instruction and an undefined instruction. When one of them is accepted, the block produces in a single clock cycle every write that entry needs. It writes a return address for the link register of the new mode and copies the old status word into that mode's saved status register. It writes a new status word that carries the new mode, with interrupts masked and the wide 32-bit instruction state forced. It also supplies a program-counter value pointing at the exception vector, and it pulses a pipeline-flush output.

The core presents its current status word, its current program counter, a flag that tells whether it runs in the compact 16-bit instruction state, and a control bit that moves the vector table to the top of the address space. The write outputs are registered and valid for exactly one cycle after the request is sampled. The register file, the status registers and the fetch unit consume them in that cycle. The handler code and the return path are outside this block.

Top module: `exc_entry`

## Requirements
- R1: After reset and until a request is accepted, `wrEn` and `flush` are low.
- R2: An interrupt request is ignored while bit 7 (interrupt mask) of `statusIn` is 1: no write and no flush follow.
- R3: The target mode written to `wrMode` and to bits [4:0] of `statusData` is 5'h12 for an interrupt, 5'h13 for a software interrupt and 5'h1B for an undefined instruction.
- R4: For interrupt entry `lrData` equals `pcIn` minus the instruction width plus 4, where the width is 2 when `narrowState` is 1 and 4 when it is 0.
- R5: For software-interrupt and undefined-instruction entry `lrData` equals `pcIn` minus the instruction width.
- R6: `pcData` is 0x04 for undefined, 0x08 for software interrupt and 0x18 for interrupt entry.
- R7: When `highVectors` is 1 the vector in `pcData` is ORed with 0xFFFF0000.
- R8: `spsrData` equals the `statusIn` value sampled with the request.
- R9: `statusData` equals the old status word with bits [4:0] replaced by the new mode, bit 7 set and bit 5 (compact-state flag) cleared; all other bits are kept.
- R10: When several requests are sampled together, an undefined instruction wins over a software interrupt, which wins over an interrupt.
- R11: Entry takes one cycle: `wrEn` and `flush` are high together for exactly the cycle after an accepted request and low after a cycle without one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| statusIn | input | 32 | Current status word |
| pcIn | input | 32 | Current program counter |
| narrowState | input | 1 | 1 = compact 16-bit instruction state |
| highVectors | input | 1 | 1 = vector table at 0xFFFF0000 |
| irqReq | input | 1 | External interrupt request |
| swiReq | input | 1 | Software-interrupt instruction request |
| undefReq | input | 1 | Undefined-instruction request |
| wrEn | output | 1 | Commit strobe for all entry writes |
| wrMode | output | 5 | Mode whose banked link and saved-status registers are written |
| lrData | output | 32 | Return address for the banked link register |
| spsrData | output | 32 | Value for the banked saved status register |
| statusData | output | 32 | New current status word |
| pcData | output | 32 | New program counter (vector) |
| flush | output | 1 | Pipeline flush pulse |

## Verification
The bench targets the return-address arithmetic in both instruction states for each exception kind. A design that applies the +4 to the wrong kind, or that ignores the state flag, is off by 2 or 4 in `lrData`. Masked interrupts are driven on their own and together with other requests: a sequencer that ignores the mask enters interrupt mode and flushes when it should stay quiet. Simultaneous requests and relocated vectors are also driven. A wrong priority shows as the wrong mode and vector, and a missing OR leaves the handler address in low memory. Back-to-back and idle cycles check that the commit strobe is a single-cycle pulse and that the written status word masks interrupts and clears the compact-state flag.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int MODE_W       = 5;
  localparam int IRQ_MASK_BIT = 7;
  localparam int NARROW_BIT   = 5;

  localparam logic [MODE_W-1:0] MODE_IRQ = 5'h12;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'h13;
  localparam logic [MODE_W-1:0] MODE_UND = 5'h1B;

  localparam logic [7:0] VEC_UND = 8'h04;
  localparam logic [7:0] VEC_SWI = 8'h08;
  localparam logic [7:0] VEC_IRQ = 8'h18;

  typedef enum logic [1:0] {
    EXC_NONE = 2'd0,
    EXC_UND  = 2'd1,
    EXC_SWI  = 2'd2,
    EXC_IRQ  = 2'd3
  } excKind_e;

  typedef struct packed {
    logic     fire;
    excKind_e kind;
  } excStrobe_t;
endpackage

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       irqReq,
  input  logic       swiReq,
  input  logic       undefReq,
  input  logic       irqMasked,
  output excStrobe_t strobe,
  output logic       flush
);
  // Requests tied to the current instruction outrank the external one.
  always_comb begin
    strobe.fire = 1'b1;
    if (undefReq)                 strobe.kind = EXC_UND;
    else if (swiReq)              strobe.kind = EXC_SWI;
    else if (irqReq && !irqMasked) strobe.kind = EXC_IRQ;
    else begin
      strobe.kind = EXC_NONE;
      strobe.fire = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) flush <= 1'b0;
    else       flush <= strobe.fire;
  end
endmodule

// File: rtl/exc_datapath.sv
module exc_datapath
  import exc_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int HIVEC_LOW_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  excStrobe_t        strobe,
  input  logic [DATA_W-1:0] statusIn,
  input  logic [DATA_W-1:0] pcIn,
  input  logic              narrowState,
  input  logic              highVectors,
  output logic              wrEn,
  output logic [MODE_W-1:0] wrMode,
  output logic [DATA_W-1:0] lrData,
  output logic [DATA_W-1:0] spsrData,
  output logic [DATA_W-1:0] statusData,
  output logic [DATA_W-1:0] pcData
);
  localparam logic [DATA_W-1:0] HIVEC_MASK = {{(DATA_W-HIVEC_LOW_W){1'b1}}, {HIVEC_LOW_W{1'b0}}};
  localparam logic [DATA_W-1:0] WIDTH_NARROW = DATA_W'(2);
  localparam logic [DATA_W-1:0] WIDTH_WIDE   = DATA_W'(4);

  logic [MODE_W-1:0] modeNext;
  logic [DATA_W-1:0] vecNext;
  logic [DATA_W-1:0] instWidth;
  logic [DATA_W-1:0] lrNext;
  logic [DATA_W-1:0] statusNext;

  always_comb begin
    unique case (strobe.kind)
      EXC_UND: begin modeNext = MODE_UND; vecNext = DATA_W'(VEC_UND); end
      EXC_SWI: begin modeNext = MODE_SVC; vecNext = DATA_W'(VEC_SWI); end
      EXC_IRQ: begin modeNext = MODE_IRQ; vecNext = DATA_W'(VEC_IRQ); end
      default: begin modeNext = '0;       vecNext = '0;               end
    endcase
    if (highVectors) vecNext = vecNext | HIVEC_MASK;
  end

  always_comb begin
    instWidth = narrowState ? WIDTH_NARROW : WIDTH_WIDE;
    lrNext    = pcIn - instWidth;
    if (strobe.kind == EXC_IRQ) lrNext = lrNext + WIDTH_WIDE;
  end

  always_comb begin
    statusNext               = statusIn;
    statusNext[MODE_W-1:0]   = modeNext;
    statusNext[IRQ_MASK_BIT] = 1'b1;
    statusNext[NARROW_BIT]   = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrEn       <= 1'b0;
      wrMode     <= '0;
      lrData     <= '0;
      spsrData   <= '0;
      statusData <= '0;
      pcData     <= '0;
    end else begin
      wrEn <= strobe.fire;
      if (strobe.fire) begin
        wrMode     <= modeNext;
        lrData     <= lrNext;
        spsrData   <= statusIn;
        statusData <= statusNext;
        pcData     <= vecNext;
      end
    end
  end
endmodule

// File: rtl/exc_entry.sv
module exc_entry
  import exc_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int HIVEC_LOW_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] statusIn,
  input  logic [DATA_W-1:0] pcIn,
  input  logic              narrowState,
  input  logic              highVectors,
  input  logic              irqReq,
  input  logic              swiReq,
  input  logic              undefReq,
  output logic              wrEn,
  output logic [4:0]        wrMode,
  output logic [DATA_W-1:0] lrData,
  output logic [DATA_W-1:0] spsrData,
  output logic [DATA_W-1:0] statusData,
  output logic [DATA_W-1:0] pcData,
  output logic              flush
);
  excStrobe_t strobe;

  exc_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .irqReq   (irqReq),
    .swiReq   (swiReq),
    .undefReq (undefReq),
    .irqMasked(statusIn[IRQ_MASK_BIT]),
    .strobe   (strobe),
    .flush    (flush)
  );

  exc_datapath #(.DATA_W(DATA_W), .HIVEC_LOW_W(HIVEC_LOW_W)) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .statusIn   (statusIn),
    .pcIn       (pcIn),
    .narrowState(narrowState),
    .highVectors(highVectors),
    .wrEn       (wrEn),
    .wrMode     (wrMode),
    .lrData     (lrData),
    .spsrData   (spsrData),
    .statusData (statusData),
    .pcData     (pcData)
  );
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] statusIn,
  input logic              highVectors,
  input logic              irqReq,
  input logic              swiReq,
  input logic              undefReq,
  input logic              wrEn,
  input logic [4:0]        wrMode,
  input logic [DATA_W-1:0] spsrData,
  input logic [DATA_W-1:0] statusData,
  input logic [DATA_W-1:0] pcData,
  input logic              flush
);
  a_r2_masked_irq: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && statusIn[7] && !swiReq && !undefReq) |=> (!flush && !wrEn));

  a_r3_irq_mode: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && !statusIn[7] && !swiReq && !undefReq) |=> (wrMode == 5'h12));

  a_r7_high_vec: assert property (@(posedge clk) disable iff (!rstN)
    ((undefReq || swiReq) && highVectors) |=> (pcData[31:16] == 16'hFFFF));

  a_r8_saved_status: assert property (@(posedge clk) disable iff (!rstN)
    (undefReq || swiReq) |=> (spsrData == $past(statusIn)));

  a_r9_masked_wide: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (statusData[7] && !statusData[5] && statusData[4:0] == wrMode));

  a_r10_undef_wins: assert property (@(posedge clk) disable iff (!rstN)
    undefReq |=> (wrMode == 5'h1B && pcData[7:0] == 8'h04));

  a_r11_flush_with_write: assert property (@(posedge clk) disable iff (!rstN)
    flush == wrEn);

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!irqReq && !swiReq && !undefReq) |=> !wrEn);
endmodule

bind exc_entry exc_entry_chk #(.DATA_W(DATA_W)) i_exc_entry_chk (
  .clk        (clk),
  .rstN       (rstN),
  .statusIn   (statusIn),
  .highVectors(highVectors),
  .irqReq     (irqReq),
  .swiReq     (swiReq),
  .undefReq   (undefReq),
  .wrEn       (wrEn),
  .wrMode     (wrMode),
  .spsrData   (spsrData),
  .statusData (statusData),
  .pcData     (pcData),
  .flush      (flush)
);

// File: tb/test_exc_entry.sv
module test_exc_entry;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] statusIn = '0;
  logic [31:0] pcIn = '0;
  logic        narrowState = 1'b0;
  logic        highVectors = 1'b0;
  logic        irqReq = 1'b0;
  logic        swiReq = 1'b0;
  logic        undefReq = 1'b0;
  logic        wrEn;
  logic [4:0]  wrMode;
  logic [31:0] lrData, spsrData, statusData, pcData;
  logic        flush;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  typedef struct {
    bit          fire;
    logic [4:0]  mode;
    logic [31:0] lr;
    logic [31:0] spsr;
    logic [31:0] status;
    logic [31:0] pc;
    string       tag;
  } expItem_t;

  expItem_t scoreQ[$];

  always #4 clk = ~clk;

  exc_entry i_exc_entry (
    .clk(clk), .rstN(rstN), .statusIn(statusIn), .pcIn(pcIn),
    .narrowState(narrowState), .highVectors(highVectors),
    .irqReq(irqReq), .swiReq(swiReq), .undefReq(undefReq),
    .wrEn(wrEn), .wrMode(wrMode), .lrData(lrData), .spsrData(spsrData),
    .statusData(statusData), .pcData(pcData), .flush(flush)
  );

  // Driver: applies one cycle of stimulus and queues the expected outcome.
  task automatic drive(input logic [31:0] st, input logic [31:0] pc, input bit nar,
                       input bit hv, input bit irq, input bit swi, input bit und,
                       input string tag);
    expItem_t e;
    logic [31:0] w;
    @(negedge clk);
    statusIn = st; pcIn = pc; narrowState = nar; highVectors = hv;
    irqReq = irq; swiReq = swi; undefReq = und;
    w = nar ? 32'd2 : 32'd4;
    e.tag = tag;
    e.fire = 1'b1;
    e.lr = '0; e.pc = '0; e.mode = '0;
    if (und) begin
      e.mode = 5'h1B; e.pc = 32'h04; e.lr = pc - w;
    end else if (swi) begin
      e.mode = 5'h13; e.pc = 32'h08; e.lr = pc - w;
    end else if (irq && !st[7]) begin
      e.mode = 5'h12; e.pc = 32'h18; e.lr = pc - w + 32'd4;
    end else begin
      e.fire = 1'b0;
    end
    if (hv) e.pc = e.pc | 32'hFFFF0000;
    e.spsr = st;
    e.status = {st[31:8], 1'b1, st[6], 1'b0, e.mode};
    scoreQ.push_back(e);
  endtask

  // Monitor: compares the registered outputs just after each edge.
  always @(posedge clk) begin
    #2;
    if (scoreQ.size() > 0) begin
      expItem_t e;
      e = scoreQ.pop_front();
      checks++;
      if (wrEn !== e.fire || flush !== e.fire) begin
        errors++;
        $display("FAIL %s strobe: wrEn=%b flush=%b expected=%b", e.tag, wrEn, flush, e.fire);
      end else if (e.fire) begin
        checks++;
        if ({wrMode, lrData, spsrData, statusData, pcData} !==
            {e.mode, e.lr, e.spsr, e.status, e.pc}) begin
          errors++;
          $display("FAIL %s data: mode=%h lr=%h spsr=%h st=%h pc=%h expected mode=%h lr=%h spsr=%h st=%h pc=%h",
                   e.tag, wrMode, lrData, spsrData, statusData, pcData,
                   e.mode, e.lr, e.spsr, e.status, e.pc);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (wrEn !== 1'b0 || flush !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: wrEn=%b flush=%b expected=0", wrEn, flush);
    end
    @(negedge clk);
    rstN = 1'b1;

    drive(32'h0000_001F, 32'h0000_1000, 0, 0, 0, 0, 0, "R1 idle");
    drive(32'h6000_001F, 32'h0000_2008, 0, 0, 1, 0, 0, "R4 R3 R6 R8 R9 irq wide");
    drive(32'h0000_003F, 32'h0000_3004, 1, 0, 1, 0, 0, "R4 irq narrow");
    drive(32'h0000_009F, 32'h0000_4000, 0, 0, 1, 0, 0, "R2 irq masked");
    drive(32'h0000_0010, 32'h0000_5010, 0, 0, 0, 1, 0, "R5 R3 R6 swi wide");
    drive(32'h8000_0030, 32'h0000_5012, 1, 0, 0, 1, 0, "R5 swi narrow");
    drive(32'h0000_0010, 32'h0000_6008, 0, 0, 0, 0, 1, "R5 R3 R6 undef wide");
    drive(32'h0000_0030, 32'h0000_6002, 1, 1, 0, 0, 1, "R7 R5 undef narrow high");
    drive(32'h0000_001F, 32'h0000_7000, 0, 1, 1, 0, 0, "R7 irq high");
    drive(32'h0000_001F, 32'h0000_8000, 0, 0, 1, 1, 1, "R10 all three");
    drive(32'h0000_001F, 32'h0000_8100, 0, 0, 1, 1, 0, "R10 swi over irq");
    drive(32'h0000_009F, 32'h0000_8200, 0, 0, 1, 1, 0, "R10 R2 swi with masked irq");
    drive(32'h0000_001F, 32'h0000_0002, 1, 0, 1, 0, 0, "R4 low pc");
    drive(32'h0000_001F, 32'h0000_0000, 0, 0, 0, 1, 0, "R5 pc wrap");
    drive(32'h0000_001F, 32'h0000_9000, 0, 0, 0, 0, 0, "R11 idle after entry");
    drive(32'h0000_001F, 32'h0000_9000, 0, 0, 0, 0, 0, "R11 idle again");

    @(negedge clk);
    irqReq = 0; swiReq = 0; undefReq = 0;
    repeat (3) @(posedge clk);
    #3;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule